// File: doc/BRIEF.md
# Time-of-Day Counter with Access Actions

This block keeps the running time of a packet-timestamping switch as a seconds count and a nanoseconds count. On every reference clock cycle the nanoseconds advance by a fixed nominal step. When they reach one billion they fold over into the seconds. Every port stamp and scheduled event in the switch is taken from this counter.

Software reaches the counter through a small strobe-based register port. Three staging registers hold seconds-high, seconds-low and nanoseconds. A fourth register holds a one-shot command. The command can do one of three things:

- take a coherent snapshot of the live time into the staging registers;
- overwrite the live time from the staging registers;
- nudge the live time by a signed nanosecond offset without stopping it.

A backward nudge that lands just below zero leaves the nanosecond field, for a short time, holding a code near 2^30. A reader must interpret that code as a small negative value.

Top module: `tod_clock`

## Requirements
- R1: A synchronous reset sets the live seconds and nanoseconds to zero and the command register to IDLE (reads back 0).
- R2: In a cycle with no LOAD or DELTA executing, the nanoseconds grow by NS_INC (default 8). A sum of 1,000,000,000 or more has one billion taken off and adds one to the seconds. Seconds wrap modulo 2^48.
- R3: Register map, on a 2-bit address:
  - address 1: seconds [47:32] in data bits [15:0];
  - address 2: seconds [31:0];
  - address 3: nanoseconds in bits [29:0];
  - unused bits read as zero.
  Writing these staging registers does not change the live counter. They read back what was last written.
- R4: The command register is at address 0, bits [1:0]: IDLE=0, SAVE=1, LOAD=2, DELTA=3. A write latches at the next edge and reads back for one cycle. The command executes on the following edge, and the register returns to IDLE at that same edge.
- R5: SAVE copies the live seconds and nanoseconds, as they stood just before the executing edge, into all three staging registers. The live counter keeps counting.
- R6: LOAD copies the staging seconds and nanoseconds into the live counter, which counts on from there on the next edge.
- R7: DELTA sets the nanoseconds to their old value plus NS_INC plus the staged nanoseconds, read as a signed 30-bit offset (bit 29 is the sign). The staged seconds are ignored.
- R8: A DELTA whose sum reaches one billion or more carries: one billion is taken off and the seconds go up by one.
- R9: A DELTA whose sum r lies in -16..-1 leaves the seconds unchanged and stores 2^30+r (0x3FFFFFF0..0x3FFFFFFF). From there the field counts on up through zero.
- R10: A DELTA whose sum is below -16 borrows: the nanoseconds become r plus one billion and the seconds drop by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_wr | input | 1 | Register write strobe |
| acc_addr | input | 2 | Register address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_addr (combinational) |
| tod_sec | output | 48 | Live seconds |
| tod_ns | output | 30 | Live nanoseconds (negative window codes possible) |

## Verification
The range assertion on the live nanoseconds takes for granted that a LOAD never leaves a value it cannot repair. It relies on the tick after a LOAD folding any loaded code back into 0..999,999,999 or into the negative window. The bench therefore exempts only the executing LOAD cycle from that check, and loads only codes below 2^30.

The command-clearing assertion assumes software does not rewrite the command register in the cycle a command executes. The bench always lets an executing edge pass before its next write.

Every DELTA offset the bench stages has a magnitude below half a second. This keeps each sum within one carry or one borrow.

// File: rtl/tod_pkg.sv
package tod_pkg;

   localparam int NS_PER_SEC = 1_000_000_000;
   localparam int CMD_W      = 2;

   localparam int REG_CMD    = 0;
   localparam int REG_SEC_HI = 1;
   localparam int REG_SEC_LO = 2;
   localparam int REG_NSEC   = 3;

   typedef enum logic [CMD_W-1:0] {
      CMD_IDLE  = 2'd0,
      CMD_SAVE  = 2'd1,
      CMD_LOAD  = 2'd2,
      CMD_DELTA = 2'd3
   } tod_cmd_e;

endpackage

// File: rtl/tod_stage_regs.sv
module tod_stage_regs
   import tod_pkg::*;
#(
   parameter int SEC_W  = 48,
   parameter int NS_W   = 30,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SEC_W-1:0]  live_sec,
   input  logic [NS_W-1:0]   live_ns,
   output tod_cmd_e          cmd_o,
   output logic [SEC_W-1:0]  stage_sec_o,
   output logic [NS_W-1:0]   stage_ns_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int SEC_HI_W = SEC_W - DATA_W;

   tod_cmd_e            cmd_q;
   logic [SEC_HI_W-1:0] sec_hi_q;
   logic [DATA_W-1:0]   sec_lo_q;
   logic [NS_W-1:0]     nsec_q;

   logic wr_cmd, wr_hi, wr_lo, wr_ns, do_save;

   assign wr_cmd  = wr_en && (addr == ADDR_W'(REG_CMD));
   assign wr_hi   = wr_en && (addr == ADDR_W'(REG_SEC_HI));
   assign wr_lo   = wr_en && (addr == ADDR_W'(REG_SEC_LO));
   assign wr_ns   = wr_en && (addr == ADDR_W'(REG_NSEC));
   assign do_save = (cmd_q == CMD_SAVE);

   // one-shot command: a new write wins, otherwise fall back to idle
   always_ff @(posedge clk) begin
      if (rst)
         cmd_q <= CMD_IDLE;
      else if (wr_cmd)
         cmd_q <= tod_cmd_e'(wdata[CMD_W-1:0]);
      else if (cmd_q != CMD_IDLE)
         cmd_q <= CMD_IDLE;
   end

   // staging registers: snapshot has priority over software writes
   always_ff @(posedge clk) begin
      if (rst) begin
         sec_hi_q <= '0;
         sec_lo_q <= '0;
         nsec_q   <= '0;
      end else if (do_save) begin
         sec_hi_q <= live_sec[SEC_W-1:DATA_W];
         sec_lo_q <= live_sec[DATA_W-1:0];
         nsec_q   <= live_ns;
      end else begin
         if (wr_hi) sec_hi_q <= wdata[SEC_HI_W-1:0];
         if (wr_lo) sec_lo_q <= wdata;
         if (wr_ns) nsec_q   <= wdata[NS_W-1:0];
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr)
         ADDR_W'(REG_CMD):    rdata_o = DATA_W'(cmd_q);
         ADDR_W'(REG_SEC_HI): rdata_o = DATA_W'(sec_hi_q);
         ADDR_W'(REG_SEC_LO): rdata_o = sec_lo_q;
         ADDR_W'(REG_NSEC):   rdata_o = DATA_W'(nsec_q);
         default:             rdata_o = '0;
      endcase
   end

   assign cmd_o       = cmd_q;
   assign stage_sec_o = {sec_hi_q, sec_lo_q};
   assign stage_ns_o  = nsec_q;

   // R3
   hi_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_hi && !do_save) |=> (sec_hi_q == $past(wdata[SEC_HI_W-1:0])));

endmodule

// File: rtl/tod_step.sv
module tod_step
   import tod_pkg::*;
#(
   parameter int SEC_W   = 48,
   parameter int NS_W    = 30,
   parameter int NS_INC  = 8,
   parameter int NEG_WIN = 16
) (
   input  tod_cmd_e         cmd,
   input  logic [SEC_W-1:0] sec_q,
   input  logic [NS_W-1:0]  ns_q,
   input  logic [SEC_W-1:0] stage_sec,
   input  logic [NS_W-1:0]  stage_ns,
   output logic [SEC_W-1:0] sec_d,
   output logic [NS_W-1:0]  ns_d
);

   localparam int EXT_W = NS_W + 3;
   localparam int PAD_W = EXT_W - NS_W;
   localparam logic signed [EXT_W-1:0] K_SEC = EXT_W'(NS_PER_SEC);
   localparam logic signed [EXT_W-1:0] K_INC = EXT_W'(NS_INC);
   localparam logic signed [EXT_W-1:0] K_NEG = -(EXT_W'(NEG_WIN));

   logic                    in_win;
   logic signed [EXT_W-1:0] cur_v, off_v, sum_v;

   generate
      if (NEG_WIN > 0) begin : g_win
         localparam logic [NS_W-1:0] WIN_LO = NS_W'((2 ** NS_W) - NEG_WIN);
         assign in_win = (ns_q >= WIN_LO);
      end else begin : g_nowin
         assign in_win = 1'b0;
      end
   endgenerate

   assign cur_v = in_win ? {{PAD_W{ns_q[NS_W-1]}}, ns_q} : {{PAD_W{1'b0}}, ns_q};
   assign off_v = (cmd == CMD_DELTA) ? {{PAD_W{stage_ns[NS_W-1]}}, stage_ns} : '0;
   assign sum_v = cur_v + K_INC + off_v;

   always_comb begin
      if (cmd == CMD_LOAD) begin
         sec_d = stage_sec;
         ns_d  = stage_ns;
      end else if (sum_v >= K_SEC) begin
         sec_d = sec_q + SEC_W'(1);
         ns_d  = NS_W'(sum_v - K_SEC);
      end else if (sum_v < K_NEG) begin
         sec_d = sec_q - SEC_W'(1);
         ns_d  = NS_W'(sum_v + K_SEC);
      end else begin
         sec_d = sec_q;
         ns_d  = NS_W'(sum_v);
      end
   end

endmodule

// File: rtl/tod_clock.sv
module tod_clock
   import tod_pkg::*;
#(
   parameter int SEC_W   = 48,
   parameter int NS_W    = 30,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 2,
   parameter int NS_INC  = 8,
   parameter int NEG_WIN = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic [SEC_W-1:0]  tod_sec,
   output logic [NS_W-1:0]   tod_ns
);

   generate
      if (SEC_W <= DATA_W || SEC_W > 2 * DATA_W) begin : g_bad_sec
         $error("SEC_W must span exactly two data words");
      end
      if (NS_W > 30 || (2 ** NS_W) <= NS_PER_SEC) begin : g_bad_ns
         $error("NS_W must hold one billion and stay at most 30");
      end
      if (NS_INC <= 0 || NS_INC >= NS_PER_SEC) begin : g_bad_inc
         $error("NS_INC out of range");
      end
      if (NEG_WIN < 0 || NEG_WIN > 256) begin : g_bad_win
         $error("NEG_WIN out of range");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W too small for four registers");
      end
   endgenerate

   tod_cmd_e         cmd;
   logic [SEC_W-1:0] stage_sec, sec_q, sec_d;
   logic [NS_W-1:0]  stage_ns, ns_q, ns_d;

   tod_stage_regs #(
      .SEC_W (SEC_W),
      .NS_W  (NS_W),
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
   ) u_stage (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (acc_wr),
      .addr       (acc_addr),
      .wdata      (acc_wdata),
      .live_sec   (sec_q),
      .live_ns    (ns_q),
      .cmd_o      (cmd),
      .stage_sec_o(stage_sec),
      .stage_ns_o (stage_ns),
      .rdata_o    (acc_rdata)
   );

   tod_step #(
      .SEC_W  (SEC_W),
      .NS_W   (NS_W),
      .NS_INC (NS_INC),
      .NEG_WIN(NEG_WIN)
   ) u_step (
      .cmd      (cmd),
      .sec_q    (sec_q),
      .ns_q     (ns_q),
      .stage_sec(stage_sec),
      .stage_ns (stage_ns),
      .sec_d    (sec_d),
      .ns_d     (ns_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sec_q <= '0;
         ns_q  <= '0;
      end else begin
         sec_q <= sec_d;
         ns_q  <= ns_d;
      end
   end

   assign tod_sec = sec_q;
   assign tod_ns  = ns_q;

   localparam logic [NS_W-1:0] NS_TOP = NS_W'(NS_PER_SEC);
   localparam logic [NS_W-1:0] NS_WLO = NS_W'((2 ** NS_W) - NEG_WIN);

   // R4
   cmd_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd != CMD_IDLE && !(acc_wr && acc_addr == ADDR_W'(REG_CMD))) |=> (cmd == CMD_IDLE));

   // R5
   save_snap_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_SAVE) |=> (stage_sec == $past(sec_q) && stage_ns == $past(ns_q)));

   // R6
   load_copy_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_LOAD) |=> (sec_q == $past(stage_sec) && ns_q == $past(stage_ns)));

   // R2
   ns_range_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd != CMD_LOAD) |=> (ns_q < NS_TOP || (NEG_WIN > 0 && ns_q >= NS_WLO)));

   // R2
   sec_step_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_IDLE || cmd == CMD_SAVE) |=>
         (sec_q == $past(sec_q) || sec_q == $past(sec_q) + SEC_W'(1)));

endmodule

// File: tb/test_tod_clock.sv
module test_tod_clock;

   localparam int TB_INC = 8;

   typedef struct packed {
      logic [47:0] sec;
      logic [29:0] ns;
      logic [31:0] dlt;
      logic [47:0] esec;
      logic [29:0] ens;
   } vec_t;

   // expected = loaded ns + 3*TB_INC + delta, normalised
   localparam vec_t VECS [9] = '{
      '{48'h5,              30'd100,         32'd1000,          48'h5,              30'd1124},        // R7 plain
      '{48'h1234_89AB_CDEF, 30'd999_999_000, 32'd2000,          48'h1234_89AB_CDF0, 30'd1024},        // R8 carry
      '{48'h9,              30'd10,          -32'sd40,          48'h9,              30'h3FFF_FFFA},   // R9 window
      '{48'h1_0000_0000,    30'd100,         -32'sd1000,        48'h0_FFFF_FFFF,    30'd999_999_124}, // R10 borrow
      '{48'h20,             30'd0,           -32'sd40,          48'h20,             30'h3FFF_FFF0},   // R9 edge -16
      '{48'h20,             30'd0,           -32'sd41,          48'h1F,             30'd999_999_983}, // R10 edge -17
      '{48'h7,              30'd600_000_000, 32'd499_999_999,   48'h8,              30'd100_000_023}, // R8 large
      '{48'h7,              30'd300_000_000, -32'sd499_999_999, 48'h6,              30'd800_000_025}, // R10 large
      '{48'hFFFF_FFFF_FFFF, 30'd999_999_976, 32'd0,             48'h0,              30'd0}            // R8 exact, wrap
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        acc_wr = 1'b0;
   logic [1:0]  acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic [47:0] tod_sec;
   logic [29:0] tod_ns;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tod_clock #(.NS_INC(TB_INC)) i_tod_clock (
      .clk      (clk),
      .rst      (rst),
      .acc_wr   (acc_wr),
      .acc_addr (acc_addr),
      .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata),
      .tod_sec  (tod_sec),
      .tod_ns   (tod_ns)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input int a, input logic [31:0] d);
      acc_wr = 1'b1;
      acc_addr = 2'(a);
      acc_wdata = d;
      @(negedge clk);
      acc_wr = 1'b0;
   endtask

   task automatic rd_reg(input int a, output logic [31:0] v);
      acc_addr = 2'(a);
      #1;
      v = acc_rdata;
   endtask

   task automatic load_tod(input logic [47:0] s, input logic [29:0] n);
      wr_reg(1, {16'h0, s[47:32]});
      wr_reg(2, s[31:0]);
      wr_reg(3, {2'b0, n});
      wr_reg(0, 32'd2);
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      chk("R1 sec", 64'(tod_sec), 64'h0);
      chk("R1 ns", 64'(tod_ns), 64'h0);
      rd_reg(0, v);
      chk("R1 cmd", 64'(v), 64'h0);

      // R2 free running count
      repeat (5) @(negedge clk);
      chk("R2 count", 64'(tod_ns), 64'd40);

      // vector table: load, stage offset, delta
      for (int i = 0; i < 9; i++) begin
         load_tod(VECS[i].sec, VECS[i].ns);
         chk("R6 load sec", 64'(tod_sec), 64'(VECS[i].sec));
         chk("R6 load ns", 64'(tod_ns), 64'(VECS[i].ns));
         wr_reg(3, {2'b0, VECS[i].dlt[29:0]});
         wr_reg(0, 32'd3);
         @(negedge clk);
         chk("R7 delta sec", 64'(tod_sec), 64'(VECS[i].esec));
         chk("R7 delta ns", 64'(tod_ns), 64'(VECS[i].ens));
      end

      // R9 negative window counts up through zero
      load_tod(48'h3, 30'd10);
      wr_reg(3, 32'h3FFF_FFD8);
      wr_reg(0, 32'd3);
      @(negedge clk);
      chk("R9 window code", 64'(tod_ns), 64'h3FFF_FFFA);
      @(negedge clk);
      chk("R9 after tick ns", 64'(tod_ns), 64'd2);
      chk("R9 after tick sec", 64'(tod_sec), 64'h3);

      // R2 rollover at one billion
      load_tod(48'h7, 30'd999_999_992);
      chk("R2 pre roll", 64'(tod_ns), 64'd999_999_992);
      @(negedge clk);
      chk("R2 roll ns", 64'(tod_ns), 64'd0);
      chk("R2 roll sec", 64'(tod_sec), 64'h8);

      // R3 staging writes leave live time running untouched
      load_tod(48'h55, 30'd1000);
      wr_reg(1, 32'hFFFF_ABCD);
      wr_reg(2, 32'h1357_2468);
      wr_reg(3, 32'h0ABC_DEF0);
      chk("R3 live ns", 64'(tod_ns), 64'd1024);
      chk("R3 live sec", 64'(tod_sec), 64'h55);
      rd_reg(1, v);
      chk("R3 read hi", 64'(v), 64'h0000_ABCD);
      rd_reg(2, v);
      chk("R3 read lo", 64'(v), 64'h1357_2468);
      rd_reg(3, v);
      chk("R3 read ns", 64'(v), 64'h0ABC_DEF0);

      // R4 / R5 snapshot
      wr_reg(0, 32'd1);
      rd_reg(0, v);
      chk("R4 pending", 64'(v), 64'd1);
      chk("R5 pre ns", 64'(tod_ns), 64'd1032);
      @(negedge clk);
      rd_reg(0, v);
      chk("R4 cleared", 64'(v), 64'd0);
      rd_reg(1, v);
      chk("R5 snap hi", 64'(v), 64'h0);
      rd_reg(2, v);
      chk("R5 snap lo", 64'(v), 64'h55);
      rd_reg(3, v);
      chk("R5 snap ns", 64'(v), 64'd1032);
      chk("R5 live runs", 64'(tod_ns), 64'd1040);

      // R4 idle command does nothing
      wr_reg(0, 32'd0);
      @(negedge clk);
      chk("R4 idle ns", 64'(tod_ns), 64'd1056);
      chk("R4 idle sec", 64'(tod_sec), 64'h55);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule